// File: doc/BRIEF.md
# Masked Dual Slave Address Matcher

This block decides whether a slave address byte received on a two-wire serial bus selects this device. The byte holds a 7-bit address in bits 7:1 and the read/write direction in bit 0. The block compares the address against a set of programmable own-address slots. The default build has two slots. Each slot has a per-bit don't-care mask, and each slot also has a general call enable.

The surrounding controller presents the complete byte together with a one-cycle valid strobe. In that same cycle the block answers with a hit pulse, the index of the winning slot, and a flag that is set when the hit came from the general call address. The direction bit of every accepted byte is held in a register until the next hit. While the controller runs as a bus master, the own-address settings play no part and nothing is accepted.

Top module: `dual_addr_filter`

## Requirements
- R1: A slot whose mask is all zero hits only when the received bits 7:1 equal bits 7:1 of that slot's address byte. In that case `hit` is 1 and `hit_idx` gives the slot number.
- R2: A mask bit of 1 at position k (mask bit k lines up with received bit k+1) lets received bit k+1 take either value. An unmasked bit that differs prevents a hit for that slot.
- R3: A hit occurs when any one slot matches. When only slot 1 matches, `hit_idx` is 1.
- R4: When several slots match, `hit_idx` reports the lowest-numbered matching slot.
- R5: While `master_mode` is 1, `hit` and `gc_hit` stay 0 and `rw_latched` keeps its value.
- R6: The received byte 0x00 hits only through a slot whose address byte has bit 0 set. Such a hit sets `gc_hit` to 1 and reports the lowest such slot in `hit_idx`. A received address of zero never hits through the ordinary compare, whatever the masks are. The byte 0x01 never hits.
- R7: `hit` is 1 only in a cycle where `rx_valid` is 1. It is combinational and has no delay.
- R8: At the clock edge that ends a hit cycle, `rw_latched` takes received bit 0. At every other edge it holds its value.
- R9: After reset, `rw_latched` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | ADDR_W+1 | Received address byte: address in the upper bits, direction in bit 0 |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is complete |
| master_mode | input | 1 | Controller is bus master; matching is suppressed |
| own_addr_cfg | input | NUM_SLOTS*(ADDR_W+1) | Per-slot byte: own address in bits ADDR_W:1, general call enable in bit 0; slot 0 in the low byte |
| own_mask_cfg | input | NUM_SLOTS*ADDR_W | Per-slot don't-care mask, aligned to the address bits; slot 0 in the low bits |
| hit | output | 1 | Address accepted this cycle |
| hit_idx | output | IDX_W | Winning slot number |
| gc_hit | output | 1 | The accepted byte was the general call address |
| rw_latched | output | 1 | Direction bit of the last accepted byte |

## Verification
Most of the path is combinational, so a fault in the compare, mask or priority logic shows up at `hit`, `hit_idx` or `gc_hit` in the same cycle as the strobe. A corrupted direction register shows up one edge later. It appears either as a wrong `rw_latched` after a hit, or as a value that drifts across cycles with no hit. The directed scenarios give each slot its own address, mask and general-call setting, so that every wrong selection changes a port value in a visible way.

// File: rtl/dual_addr_filter_pkg.sv
package dual_addr_filter_pkg;
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/addr_slot_cmp.sv
module addr_slot_cmp #(
   parameter int unsigned ADDR_W     = 7,
   parameter bit          GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W:0]   rx_byte,
   input  logic [ADDR_W:0]   cfg_addr,
   input  logic [ADDR_W-1:0] cfg_mask,
   output logic              direct_hit,
   output logic              gc_hit
);
   logic [ADDR_W-1:0] care_diff;
   logic              addr_zero;

   always_comb begin
      care_diff  = (rx_byte[ADDR_W:1] ^ cfg_addr[ADDR_W:1]) & ~cfg_mask;
      addr_zero  = (rx_byte[ADDR_W:1] == '0);
      direct_hit = (care_diff == '0) && !addr_zero;
   end

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit = (rx_byte == '0) && cfg_addr[0];
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/slot_prio_pick.sv
module slot_prio_pick #(
   parameter int unsigned N     = 2,
   parameter int unsigned IDX_W = 1
) (
   input  logic [N-1:0]     req,
   output logic             any_req,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx     = '0;
      any_req = |req;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/rw_hold_reg.sv
module rw_hold_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (capture) q <= d;
   end
endmodule

// File: rtl/dual_addr_filter.sv
module dual_addr_filter
   import dual_addr_filter_pkg::*;
#(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned NUM_SLOTS  = 2,
   parameter bit          GC_SUPPORT = 1'b1,
   localparam int unsigned BYTE_W    = ADDR_W + 1,
   localparam int unsigned IDX_W     = idx_width(NUM_SLOTS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [BYTE_W-1:0]             rx_byte,
   input  logic                          rx_valid,
   input  logic                          master_mode,
   input  logic [NUM_SLOTS*BYTE_W-1:0]   own_addr_cfg,
   input  logic [NUM_SLOTS*ADDR_W-1:0]   own_mask_cfg,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx,
   output logic                          gc_hit,
   output logic                          rw_latched
);
   initial begin
      if (ADDR_W < 1)    $error("ADDR_W must be at least 1");
      if (NUM_SLOTS < 1) $error("NUM_SLOTS must be at least 1");
   end

   logic [NUM_SLOTS-1:0] direct_req;
   logic [NUM_SLOTS-1:0] gc_req;
   logic [NUM_SLOTS-1:0] slot_req;
   logic                 any_req;
   logic                 qualify;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      addr_slot_cmp #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
         .rx_byte    (rx_byte),
         .cfg_addr   (own_addr_cfg[s*BYTE_W +: BYTE_W]),
         .cfg_mask   (own_mask_cfg[s*ADDR_W +: ADDR_W]),
         .direct_hit (direct_req[s]),
         .gc_hit     (gc_req[s])
      );
      assign slot_req[s] = direct_req[s] | gc_req[s];
   end

   slot_prio_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
      .req     (slot_req),
      .any_req (any_req),
      .idx     (hit_idx)
   );

   assign qualify = rx_valid & ~master_mode;
   assign hit     = qualify & any_req;
   assign gc_hit  = qualify & (|gc_req);

   rw_hold_reg u_rw (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (hit),
      .d       (rx_byte[0]),
      .q       (rw_latched)
   );
endmodule

module dual_addr_filter_chk #(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned NUM_SLOTS = 2,
   parameter int unsigned IDX_W     = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W:0]   rx_byte,
   input logic              rx_valid,
   input logic              master_mode,
   input logic              hit,
   input logic [IDX_W-1:0]  hit_idx,
   input logic              gc_hit,
   input logic              rw_latched
);
   assert_no_hit_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode |-> (!hit && !gc_hit));
   assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> rx_valid);
   assert_gc_zero_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gc_hit |-> (hit && rx_byte == '0));
   assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (int'(hit_idx) < NUM_SLOTS));
   assert_rw_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (rw_latched == $past(rx_byte[0])));
   assert_rw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(rw_latched));
endmodule

bind dual_addr_filter dual_addr_filter_chk #(
   .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_dual_addr_filter.sv
module test_dual_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        rx_valid = 1'b0;
   logic        master_mode = 1'b0;
   logic [15:0] own_addr_cfg = '0;
   logic [13:0] own_mask_cfg = '0;
   logic        hit;
   logic [0:0]  hit_idx;
   logic        gc_hit;
   logic        rw_latched;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   dual_addr_filter i_dual_addr_filter (.*);

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // present a byte at the falling edge, look at combinational outputs shortly after
   task automatic present(input logic [7:0] b, input logic v, input logic mm);
      @(negedge clk);
      rx_byte = b; rx_valid = v; master_mode = mm;
      #2;
   endtask

   task automatic idle();
      @(negedge clk);
      rx_valid = 1'b0; master_mode = 1'b0; rx_byte = 8'h00;
   endtask

   // slot0 address 0x28 exact; slot1 address 0x50 with low two bits don't-care
   task automatic setup_cfg();
      own_addr_cfg = {8'hA0, 8'h50};
      own_mask_cfg = {7'h03, 7'h00};
   endtask

   task automatic t_reset();
      #2;
      chk("R9 rw after reset", rw_latched, 0);
      chk("R7 hit idle", hit, 0);
   endtask

   task automatic t_exact();
      setup_cfg();
      present(8'h50, 1, 0);
      chk("R1 exact hit", hit, 1);
      chk("R1 exact idx", hit_idx, 0);
      chk("R1 no gc", gc_hit, 0);
      present(8'h52, 1, 0);
      chk("R1 off-by-one miss", hit, 0);
      idle();
   endtask

   task automatic t_mask();
      setup_cfg();
      present(8'hA5, 1, 0);   // address 0x52, read
      chk("R2 masked hit", hit, 1);
      chk("R3 slot1 idx", hit_idx, 1);
      present(8'hA8, 1, 0);   // address 0x54, unmasked bit differs
      chk("R2 unmasked miss", hit, 0);
      idle();
   endtask

   task automatic t_rw();
      setup_cfg();
      present(8'hA5, 1, 0);
      @(negedge clk); rx_valid = 0; rx_byte = 8'h50; #2;
      chk("R8 rw captured 1", rw_latched, 1);
      present(8'h52, 1, 0);   // miss, bit0 = 0
      @(negedge clk); rx_valid = 0; #2;
      chk("R8 rw held on miss", rw_latched, 1);
      present(8'h50, 1, 0);
      @(negedge clk); rx_valid = 0; #2;
      chk("R8 rw captured 0", rw_latched, 0);
   endtask

   task automatic t_priority();
      own_addr_cfg = {8'h50, 8'h50};
      own_mask_cfg = {7'h00, 7'h7F};
      present(8'h50, 1, 0);
      chk("R4 both match idx", hit_idx, 0);
      chk("R4 both match hit", hit, 1);
      idle();
   endtask

   task automatic t_master();
      setup_cfg();
      present(8'hA5, 1, 0);
      @(negedge clk); rx_valid = 0; #2;
      present(8'h50, 1, 1);
      chk("R5 master no hit", hit, 0);
      @(negedge clk); rx_valid = 0; master_mode = 0; #2;
      chk("R5 master rw kept", rw_latched, 1);
      present(8'h00, 1, 1);
      chk("R5 master no gc", gc_hit, 0);
      idle();
   endtask

   task automatic t_gc();
      own_addr_cfg = {8'hA1, 8'h50};
      own_mask_cfg = {7'h03, 7'h00};
      present(8'h00, 1, 0);
      chk("R6 gc hit", hit, 1);
      chk("R6 gc flag", gc_hit, 1);
      chk("R6 gc idx", hit_idx, 1);
      present(8'h01, 1, 0);
      chk("R6 zero read miss", hit, 0);
      own_addr_cfg = {8'hA0, 8'h50};
      own_mask_cfg = {7'h03, 7'h7F};
      present(8'h00, 1, 0);
      chk("R6 gc disabled miss", hit, 0);
      chk("R6 gc disabled flag", gc_hit, 0);
      idle();
   endtask

   task automatic t_valid();
      setup_cfg();
      present(8'h50, 0, 0);
      chk("R7 no strobe no hit", hit, 0);
      present(8'h50, 1, 0);
      chk("R7 strobe hit", hit, 1);
      idle();
   endtask

   initial begin
      t_reset();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_exact();
      t_mask();
      t_rw();
      t_priority();
      t_master();
      t_gc();
      t_valid();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule